// File: doc/BRIEF.md
# Scaled-Index Address Adder

This block computes array element addresses for a 64-bit integer pipeline in a single operation. It takes a base (`rs2_i`) and an index (`rs1_i`). Depending on the operation code it may first zero-extend the low 32 bits of the index, then shift the index left by a fixed scale of 1, 2 or 3 bits, and then add the base. A 32-bit unsigned loop counter therefore costs the same single operation as a signed or full-width index. A further operation zero-extends and shifts the index by a 6-bit immediate and adds nothing.

The slice sits in the execute stage of a core. It registers its result one cycle after an operand set is presented with `in_valid_i`, and `out_valid_i` follows with the same delay. Codes outside the defined set return zero and raise `illegal_o`. The register file and the full instruction decoder are outside the block.

Top module: `agu_shadd`

## Requirements
- R1: Code 0 (index-add, unsigned word) gives `{32'b0, rs1[31:0]} + rs2`.
- R2: Codes 1, 2 and 3 give `(rs1 << N) + rs2` on the full 64-bit index, where N is 1, 2 or 3 respectively.
- R3: Codes 5, 6 and 7 give `({32'b0, rs1[31:0]} << N) + rs2`, where N is 1, 2 or 3 respectively. The upper 32 index bits never reach the result.
- R4: Code 4 (shift-immediate, unsigned word) gives `{32'b0, rs1[31:0]} << shamt`, with `shamt` from 0 to 63. `rs2_i` has no effect on the result.
- R5: `shamt_i` has no effect for any code other than 4.
- R6: The addition wraps modulo 2^64, and no overflow indication exists.
- R7: `out_valid_o` is high exactly one cycle after `in_valid_i` was high. `result_o` and `illegal_o` for that operand set are presented in the same cycle.
- R8: Codes 8 to 15 produce `result_o` = 0 and `illegal_o` = 1 on the following cycle. Legal codes produce `illegal_o` = 0.
- R9: While `in_valid_i` is low, `result_o` and `illegal_o` keep their last values.
- R10: During reset, `out_valid_o`, `result_o` and `illegal_o` are all zero. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Operand set present this cycle |
| op_i | input | 4 | Operation code (0..7 legal, 8..15 illegal) |
| rs1_i | input | 64 | Index operand |
| rs2_i | input | 64 | Base operand |
| shamt_i | input | 6 | Shift immediate used only by code 4 |
| out_valid_o | output | 1 | Registered result valid |
| result_o | output | 64 | Registered address result |
| illegal_o | output | 1 | Registered flag for an unsupported code |

## Verification
The assertions assume that `op_i`, `rs1_i`, `rs2_i` and `shamt_i` are known whenever `in_valid_i` is high. They also assume that no operand set arrives until the internal reset has been released. The stimulus changes inputs only on falling edges and holds them steady across the rising edge. It waits several cycles after reset before the first operand set, and it drives all inputs to fixed values during idle cycles, so every sampled value is defined.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_UW   = 4'd0,
    OP_SH1ADD   = 4'd1,
    OP_SH2ADD   = 4'd2,
    OP_SH3ADD   = 4'd3,
    OP_SLLI_UW  = 4'd4,
    OP_SH1ADD_UW = 4'd5,
    OP_SH2ADD_UW = 4'd6,
    OP_SH3ADD_UW = 4'd7
  } agu_op_e;

  typedef struct packed {
    logic       legal;
    logic       zext;
    logic       add_base;
    logic       use_imm;
    logic [1:0] scale;
  } agu_ctl_t;

endpackage

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [3:0] op_i,
  output agu_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '0;
    case (op_i)
      OP_ADD_UW:    ctl_o = '{legal: 1'b1, zext: 1'b1, add_base: 1'b1, use_imm: 1'b0, scale: 2'd0};
      OP_SH1ADD:    ctl_o = '{legal: 1'b1, zext: 1'b0, add_base: 1'b1, use_imm: 1'b0, scale: 2'd1};
      OP_SH2ADD:    ctl_o = '{legal: 1'b1, zext: 1'b0, add_base: 1'b1, use_imm: 1'b0, scale: 2'd2};
      OP_SH3ADD:    ctl_o = '{legal: 1'b1, zext: 1'b0, add_base: 1'b1, use_imm: 1'b0, scale: 2'd3};
      OP_SLLI_UW:   ctl_o = '{legal: 1'b1, zext: 1'b1, add_base: 1'b0, use_imm: 1'b1, scale: 2'd0};
      OP_SH1ADD_UW: ctl_o = '{legal: 1'b1, zext: 1'b1, add_base: 1'b1, use_imm: 1'b0, scale: 2'd1};
      OP_SH2ADD_UW: ctl_o = '{legal: 1'b1, zext: 1'b1, add_base: 1'b1, use_imm: 1'b0, scale: 2'd2};
      OP_SH3ADD_UW: ctl_o = '{legal: 1'b1, zext: 1'b1, add_base: 1'b1, use_imm: 1'b0, scale: 2'd3};
      default:      ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
  parameter int XLEN = 64,
  parameter int HALF = XLEN / 2,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] idx_i,
  input  logic            zext_i,
  input  logic [SHW-1:0]  amt_i,
  output logic [XLEN-1:0] scaled_o
);
  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] stage [SHW+1];

  always_comb begin
    ext = zext_i ? {{(XLEN-HALF){1'b0}}, idx_i[HALF-1:0]} : idx_i;
  end

  assign stage[0] = ext;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int DIST = 1 << i;
    assign stage[i+1] = amt_i[i] ? {stage[i][XLEN-1-DIST:0], {DIST{1'b0}}} : stage[i];
  end

  assign scaled_o = stage[SHW];
endmodule

// File: rtl/agu_shadd.sv
module agu_shadd
  import agu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OPW = 4,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [SHW-1:0]  shamt_i,
  output logic            out_valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  logic            rst_sync_n;
  agu_ctl_t        ctl;
  logic [SHW-1:0]  amt;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] addend;
  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] res_nxt;
  logic            ill_nxt;

  logic            v_q, v_d;
  logic [XLEN-1:0] r_q, r_d;
  logic            i_q, i_d;

  agu_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  agu_decode u_dec (
    .op_i (op_i[3:0]),
    .ctl_o(ctl)
  );

  always_comb begin
    amt = ctl.use_imm ? shamt_i : {{(SHW-2){1'b0}}, ctl.scale};
  end

  agu_scaler #(.XLEN(XLEN)) u_scl (
    .idx_i   (rs1_i),
    .zext_i  (ctl.zext),
    .amt_i   (amt),
    .scaled_o(scaled)
  );

  always_comb begin
    addend  = ctl.add_base ? rs2_i : '0;
    sum     = scaled + addend;
    res_nxt = ctl.legal ? sum : '0;
    ill_nxt = ~ctl.legal;
  end

  always_comb begin
    v_d = in_valid_i;
    r_d = in_valid_i ? res_nxt : r_q;
    i_d = in_valid_i ? ill_nxt : i_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v_q <= 1'b0;
      r_q <= '0;
      i_q <= 1'b0;
    end else begin
      v_q <= v_d;
      r_q <= r_d;
      i_q <= i_d;
    end
  end

  assign out_valid_o = v_q;
  assign result_o    = r_q;
  assign illegal_o   = i_q;

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid_i |=> out_valid_o);
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid_i |=> !out_valid_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid_i |=> ($stable(result_o) && $stable(illegal_o)));
  p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid_i && op_i[OPW-1]) |=> (illegal_o && result_o == '0));
  p_slli_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid_i && op_i == OP_SLLI_UW && shamt_i[SHW-1]) |=> (result_o[XLEN/2-1:0] == '0));
  p_uw_upper_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid_i && op_i == OP_ADD_UW && rs2_i == '0) |=> (result_o[XLEN-1:XLEN/2] == '0));
endmodule

// File: tb/sim_agu_shadd.sv
module sim_agu_shadd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic [5:0]  shamt = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  agu_shadd u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op),
    .rs1_i(rs1), .rs2_i(rs2), .shamt_i(shamt),
    .out_valid_o(out_valid), .result_o(result), .illegal_o(illegal)
  );

  function automatic exp_t model(input logic [3:0] o, input logic [63:0] a,
                                 input logic [63:0] b, input logic [5:0] s, input string req);
    exp_t e;
    logic [63:0] w;
    e.req = req;
    e.ill = 1'b0;
    w = {32'h0, a[31:0]};
    case (o)
      4'd0: e.res = w + b;
      4'd1: e.res = (a * 64'd2) + b;
      4'd2: e.res = (a * 64'd4) + b;
      4'd3: e.res = (a * 64'd8) + b;
      4'd4: e.res = w << s;
      4'd5: e.res = (w * 64'd2) + b;
      4'd6: e.res = (w * 64'd4) + b;
      4'd7: e.res = (w * 64'd8) + b;
      default: begin e.res = '0; e.ill = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic [5:0] s, input string req);
    @(negedge clk);
    in_valid = 1'b1; op = o; rs1 = a; rs2 = b; shamt = s;
    sb.push_back(model(o, a, b, s, req));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 4'hF; rs1 = '1; rs2 = '1; shamt = '1;
    end
  endtask

  // monitor: compares on the falling edge after the registering edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) begin
          check("R7 unexpected valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, result, e.res);
          check({e.req, " illegal flag R8"}, {63'd0, illegal}, {63'd0, e.ill});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    check("R10 reset illegal", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;
    idle(4);
    check("R10 after release", {63'd0, out_valid}, 64'd0);

    drive(4'd0, 64'hDEAD_BEEF_8000_0001, 64'h0000_1000_0000_0000, 6'd0, "R1 add.uw");
    drive(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd17, "R1 add.uw zero base R5");
    drive(4'd1, 64'h8000_0000_0000_0003, 64'd100, 6'd0, "R2 sh1add");
    drive(4'd2, 64'h0000_0001_0000_0005, 64'h10, 6'd0, "R2 sh2add");
    drive(4'd3, 64'h1234_5678_9ABC_DEF0, 64'h1, 6'd63, "R2 sh3add shamt ignored R5");
    drive(4'd5, 64'hFFFF_FFFF_8000_0000, 64'h4, 6'd0, "R3 sh1add.uw");
    drive(4'd6, 64'hAAAA_AAAA_FFFF_FFFF, 64'h0, 6'd9, "R3 sh2add.uw R5");
    drive(4'd7, 64'h0123_4567_89AB_CDEF, 64'hF000_0000_0000_0000, 6'd0, "R3 sh3add.uw");
    drive(4'd4, 64'hFFFF_FFFF_0000_0001, 64'h5555, 6'd63, "R4 slli.uw shift 63");
    drive(4'd4, 64'hFFFF_FFFF_89AB_CDEF, 64'hFFFF, 6'd0, "R4 slli.uw shift 0");
    drive(4'd4, 64'h0000_0000_F000_000F, 64'd7, 6'd32, "R4 slli.uw shift 32");
    drive(4'd0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, "R6 wrap");
    drive(4'd3, 64'hF000_0000_0000_0000, 64'h8, 6'd0, "R6 wrap shifted out");
    drive(4'd8, 64'h1, 64'h2, 6'd1, "R8 illegal 8");
    drive(4'd15, '1, '1, '1, "R8 illegal 15");
    drive(4'd2, 64'd3, 64'd1, 6'd0, "R7 back to back");
    idle(1);
    check("R7 last valid", {63'd0, out_valid}, 64'd1);
    idle(1);
    check("R7 valid drops", {63'd0, out_valid}, 64'd0);
    check("R9 result held", result, 64'd13);
    idle(3);
    check("R9 result still held", result, 64'd13);
    check("R9 illegal held", {63'd0, illegal}, 64'd0);
    drive(4'd9, 64'h7, 64'h7, 6'd0, "R8 illegal 9");
    idle(3);
    check("R9 illegal flag held", {63'd0, illegal}, 64'd1);
    check("R8 queue drained", 64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule